// File: doc/BRIEF.md
# Sticky Status Bank with Maskable Alert

This block holds a set of sticky status bits for a multi-channel regulator controller. Each channel owns several detail registers. Every bit in them records a fault, warning or condition reported by an event input. A bit is set when its event input rises and stays set until something clears it. A per-bit mask chooses which set bits may pull the shared active-low alert output. Two summary registers per channel fold the detail registers into single bits. A third summary register folds the masks in the same way, so software can see which summary positions can no longer raise the alert.

Status bits are cleared in three ways: by writing a one to them, by a global clear strobe, or by a rising edge on the channel's run input, which marks the channel being commanded back on. The alert has a release path of its own. A successful alert-response address transmission releases it while the status bits stay set. It then drops again only when a new unmasked bit is set. The alert also returns high as soon as no set bit is left unmasked. Software reaches everything through a flat register port with a combinational read path. The address is `{channel, 5-bit index}`.

Top module: `status_alert_bank`

## Requirements
- R1: After reset every status bit and every mask bit is zero and `alert_no` is high.
- R2: A 0-to-1 transition of event bit `evt_i[(c*NUM_DET+d)*DET_W+b]` sets bit b of detail register d of channel c on that clock edge. The bit stays set after the event falls. An event held high does not set the bit again after it is cleared.
- R3: A write to index d (0 to NUM_DET-1) clears each status bit whose write-data bit is one and leaves the bits written as zero unchanged.
- R4: When a bit's rising event and any clear of that bit (write-one, global clear, run edge) fall in the same cycle, the bit ends up set.
- R5: Index 8+d reads and writes the mask of detail register d. The bit positions given by `UNMASK_BITS` in the last detail register (index NUM_DET-1) always read zero and cannot be masked (default bit 7).
- R6: `alert_no` is low in the cycle after an event newly sets a status bit whose mask bit is zero. Setting a masked bit records the status but does not pull the alert.
- R7: `alert_no` returns high in the cycle after no set status bit is left unmasked, whether because the bits were cleared or because the mask was written.
- R8: A pulse on `ara_ack_i` releases `alert_no` on the next cycle even though status bits stay set. The alert goes low again only on a later newly set unmasked bit. A new unmasked set in the same cycle as `ara_ack_i` keeps it low.
- R9: `clr_all_i` clears every status bit of every channel and leaves all masks unchanged.
- R10: A rising edge on `run_i[c]` clears every status bit of channel c only. A level held high clears nothing further.
- R11: Index 16 reads the summary word. Bit 15-d is the OR of detail register d for d<4. Bit d-3 is the OR of detail register d for d>=4. Bit 0 is the OR of bits 15:12. Index 17 returns the low byte of that word, zero-extended.
- R12: Index 18 reads the summary mask word. It uses the same positions, and a bit there is one when every bit of that detail register's mask is one. Bit 0 is one when bits 15:12 are all one.
- R13: Other indices, and channel numbers at or above NUM_CH, read zero. Writes to them and to indices 16 to 18 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CH*NUM_DET*DET_W | Event inputs, bit (c*NUM_DET+d)*DET_W+b |
| run_i | input | NUM_CH | Per-channel run level; rising edge clears that channel |
| clr_all_i | input | 1 | Global clear strobe |
| ara_ack_i | input | 1 | Successful alert-response address transmission |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | CH_W+5 | `{channel, index}` |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data |
| alert_no | output | 1 | Active-low alert |

## Verification
The bench builds the block with its default parameters: two channels of six 8-bit detail registers, with bit 7 of the last register unmaskable. Six registers per channel reach both summary bit groups: four registers feed the upper nibble and two feed the low byte outside the "none of the above" position. Ninety-six event bits are few enough to sweep every one of them through set, partial clear, full clear and alert release, and every mask register through write and summary folding. With two channels, the run-edge clear and the global clear can each be checked for touching only the state they should.

// File: rtl/sab_pkg.sv
package sab_pkg;
  localparam int SUM_W         = 16;
  localparam int IDX_W         = 5;
  localparam int IDX_MASK_BASE = 8;
  localparam int IDX_SUM_WORD  = 16;
  localparam int IDX_SUM_BYTE  = 17;
  localparam int IDX_SUM_MASK  = 18;

  // summary bit position of detail register d
  function automatic int sum_pos(input int d);
    return (d < 4) ? 15 - d : d - 3;
  endfunction
endpackage

// File: rtl/sab_detail_reg.sv
module sab_detail_reg #(
  parameter int              W     = 8,
  parameter logic [W-1:0]    FIXED = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] evt_q;

  assign rise_o = evt_i & ~evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= '0;
      status_o <= '0;
      mask_o   <= '0;
    end else begin
      evt_q    <= evt_i;
      // set beats clear
      status_o <= (status_o & ~clr_i) | rise_o;
      if (mask_we_i) mask_o <= mask_wdata_i & ~FIXED;
    end
  end
endmodule

// File: rtl/sab_summary.sv
module sab_summary #(
  parameter int NUM_DET = 6,
  parameter int W       = 8
) (
  input  logic [NUM_DET*W-1:0]      status_i,
  input  logic [NUM_DET*W-1:0]      mask_i,
  output logic [sab_pkg::SUM_W-1:0] word_o,
  output logic [sab_pkg::SUM_W-1:0] mword_o
);
  always_comb begin
    word_o  = '0;
    mword_o = '0;
    for (int d = 0; d < NUM_DET; d++) begin
      word_o[sab_pkg::sum_pos(d)]  = |status_i[d*W +: W];
      mword_o[sab_pkg::sum_pos(d)] = &mask_i[d*W +: W];
    end
    word_o[0]  = |word_o[15:12];
    mword_o[0] = &mword_o[15:12];
  end
endmodule

// File: rtl/sab_alert.sv
module sab_alert (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raise_i,
  input  logic pend_i,
  input  logic ara_i,
  output logic alert_no
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= raise_i | (armed_q & pend_i & ~ara_i);
  end

  assign alert_no = ~(armed_q & pend_i);
endmodule

// File: rtl/status_alert_bank.sv
module status_alert_bank #(
  parameter int                 NUM_CH      = 2,
  parameter int                 NUM_DET     = 6,
  parameter int                 DET_W       = 8,
  parameter logic [DET_W-1:0]   UNMASK_BITS = 8'h80,
  parameter int                 CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_CH*NUM_DET*DET_W-1:0] evt_i,
  input  logic [NUM_CH-1:0]               run_i,
  input  logic                            clr_all_i,
  input  logic                            ara_ack_i,
  input  logic                            reg_we_i,
  input  logic [CH_W+sab_pkg::IDX_W-1:0]  reg_addr_i,
  input  logic [sab_pkg::SUM_W-1:0]       reg_wdata_i,
  output logic [sab_pkg::SUM_W-1:0]       reg_rdata_o,
  output logic                            alert_no
);
  import sab_pkg::*;

  localparam int CH_BITS = NUM_DET * DET_W;
  localparam int EVT_W   = NUM_CH * CH_BITS;

  logic [CH_W-1:0]  ch_sel;
  logic [IDX_W-1:0] idx;
  logic [NUM_CH-1:0] run_q, run_rise;
  logic [EVT_W-1:0] status_flat, mask_flat, rise_flat;
  logic [SUM_W-1:0] word_a  [NUM_CH];
  logic [SUM_W-1:0] mword_a [NUM_CH];
  logic             raise, pend;
  logic             unused_wdata;

  assign ch_sel = reg_addr_i[CH_W+IDX_W-1:IDX_W];
  assign idx    = reg_addr_i[IDX_W-1:0];
  assign unused_wdata = ^reg_wdata_i[SUM_W-1:DET_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_i;
  end
  assign run_rise = run_i & ~run_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_hit;
    assign ch_hit = (ch_sel == CH_W'(c));

    for (genvar d = 0; d < NUM_DET; d++) begin : g_det
      localparam int               BASE = (c*NUM_DET + d) * DET_W;
      localparam logic [DET_W-1:0] FIX  = (d == NUM_DET-1) ? UNMASK_BITS : '0;
      logic             st_hit, mk_hit;
      logic [DET_W-1:0] clr;

      assign st_hit = reg_we_i & ch_hit & (idx == IDX_W'(d));
      assign mk_hit = reg_we_i & ch_hit & (idx == IDX_W'(IDX_MASK_BASE + d));
      assign clr    = {DET_W{clr_all_i | run_rise[c]}}
                    | (st_hit ? reg_wdata_i[DET_W-1:0] : '0);

      sab_detail_reg #(.W(DET_W), .FIXED(FIX)) u_reg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .evt_i        (evt_i[BASE +: DET_W]),
        .clr_i        (clr),
        .mask_we_i    (mk_hit),
        .mask_wdata_i (reg_wdata_i[DET_W-1:0]),
        .status_o     (status_flat[BASE +: DET_W]),
        .mask_o       (mask_flat[BASE +: DET_W]),
        .rise_o       (rise_flat[BASE +: DET_W])
      );
    end

    sab_summary #(.NUM_DET(NUM_DET), .W(DET_W)) u_sum (
      .status_i (status_flat[c*CH_BITS +: CH_BITS]),
      .mask_i   (mask_flat[c*CH_BITS +: CH_BITS]),
      .word_o   (word_a[c]),
      .mword_o  (mword_a[c])
    );
  end

  assign raise = |(rise_flat & ~mask_flat);
  assign pend  = |(status_flat & ~mask_flat);

  sab_alert u_alert (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raise_i  (raise),
    .pend_i   (pend),
    .ara_i    (ara_ack_i),
    .alert_no (alert_no)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == CH_W'(c)) begin
        for (int d = 0; d < NUM_DET; d++) begin
          if (idx == IDX_W'(d))
            reg_rdata_o[DET_W-1:0] = status_flat[(c*NUM_DET + d)*DET_W +: DET_W];
          if (idx == IDX_W'(IDX_MASK_BASE + d))
            reg_rdata_o[DET_W-1:0] = mask_flat[(c*NUM_DET + d)*DET_W +: DET_W];
        end
        if (idx == IDX_W'(IDX_SUM_WORD)) reg_rdata_o = word_a[c];
        if (idx == IDX_W'(IDX_SUM_BYTE)) reg_rdata_o = {8'h00, word_a[c][7:0]};
        if (idx == IDX_W'(IDX_SUM_MASK)) reg_rdata_o = mword_a[c];
      end
    end
  end
endmodule

// File: rtl/status_alert_bank_chk.sv
module status_alert_bank_chk #(
  parameter int N = 96
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         alert_no,
  input logic         ara_ack_i,
  input logic         clr_all_i,
  input logic         raise_i,
  input logic [N-1:0] rise_i,
  input logic [N-1:0] status_i
);
  a_r6_raise_pulls_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_i |=> !alert_no);

  a_r6_fall_needs_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alert_no) |-> $past(raise_i));

  a_r8_ara_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ara_ack_i && !raise_i) |=> alert_no);

  a_r9_clear_all_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && !(|rise_i)) |=> (status_i == '0));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_i) |=> ((status_i & $past(rise_i)) == $past(rise_i)));
endmodule

bind status_alert_bank status_alert_bank_chk #(.N(EVT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .alert_no  (alert_no),
  .ara_ack_i (ara_ack_i),
  .clr_all_i (clr_all_i),
  .raise_i   (raise),
  .rise_i    (rise_flat),
  .status_i  (status_flat)
);

// File: tb/status_alert_bank_tb_top.sv
module status_alert_bank_tb_top;
  localparam int NC = 2;
  localparam int ND = 6;
  localparam int W  = 8;
  localparam logic [7:0] UM = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NC*ND*W-1:0] evt = '0;
  logic [NC-1:0] run = '0;
  logic        clr_all = 1'b0, ara = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        alert_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] st [NC][ND];
  logic [7:0] mk [NC][ND];

  always #2 clk = ~clk;

  status_alert_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .run_i(run), .clr_all_i(clr_all),
    .ara_ack_i(ara), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .alert_no(alert_n)
  );

  function automatic int ei(int c, int d, int b);
    return (c*ND + d)*W + b;
  endfunction

  function automatic logic [5:0] ad(int c, int i);
    return 6'((c << 5) | i);
  endfunction

  function automatic logic [15:0] ew(int c);
    logic [15:0] w = '0;
    for (int d = 0; d < ND; d++) if (st[c][d] != 0) w[d < 4 ? 15-d : d-3] = 1'b1;
    w[0] = |w[15:12];
    return w;
  endfunction

  function automatic logic [15:0] em(int c);
    logic [15:0] w = '0;
    for (int d = 0; d < ND; d++) if (mk[c][d] == 8'hFF) w[d < 4 ? 15-d : d-3] = 1'b1;
    w[0] = &w[15:12];
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1; tick(); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic pulse(input int i);
    evt[i] = 1'b1; tick(); evt[i] = 1'b0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    for (int c = 0; c < NC; c++) for (int d = 0; d < ND; d++) begin st[c][d] = 0; mk[c][d] = 0; end
    repeat (3) @(posedge clk); #1; rst_n = 1'b1; tick();

    // R1 reset state
    chk("R1 alert", alert_n, 1);
    for (int c = 0; c < NC; c++) for (int d = 0; d < ND; d++) begin
      rd(ad(c, d), v);     chk("R1 status", v, 0);
      rd(ad(c, 8+d), v);   chk("R1 mask", v, 0);
    end

    // sweep every event bit
    for (int c = 0; c < NC; c++) for (int d = 0; d < ND; d++) for (int b = 0; b < W; b++) begin
      pulse(ei(c, d, b));
      st[c][d][b] = 1'b1;
      rd(ad(c, d), v);   chk("R2 set", v, 16'(st[c][d]));
      rd(ad(c, 16), v);  chk("R11 word", v, ew(c));
      rd(ad(c, 17), v);  chk("R11 byte", v, {8'h00, ew(c)[7:0]});
      chk("R6 alert low", alert_n, 0);
      wr(ad(c, d), 16'h00FF & ~(16'd1 << b));
      rd(ad(c, d), v);   chk("R3 zero bit kept", v, 16'(st[c][d]));
      wr(ad(c, d), 16'd1 << b);
      st[c][d][b] = 1'b0;
      rd(ad(c, d), v);   chk("R3 cleared", v, 0);
      chk("R7 alert high", alert_n, 1);
    end

    // R2 held event does not re-set
    evt[ei(0,0,0)] = 1'b1; tick();
    rd(ad(0,0), v); chk("R2 held set", v, 1);
    wr(ad(0,0), 16'h0001);
    rd(ad(0,0), v); chk("R2 held no reset", v, 0);
    evt[ei(0,0,0)] = 1'b0; tick();

    // R4 set beats clears
    evt[ei(0,0,3)] = 1'b1; addr = ad(0,0); wdata = 16'h0008; we = 1'b1; tick();
    we = 1'b0; evt[ei(0,0,3)] = 1'b0;
    rd(ad(0,0), v); chk("R4 set vs w1c", v, 16'h0008);
    evt[ei(1,2,5)] = 1'b1; clr_all = 1'b1; tick();
    clr_all = 1'b0; evt[ei(1,2,5)] = 1'b0;
    rd(ad(1,2), v); chk("R4 set vs global clear", v, 16'h0020);
    rd(ad(0,0), v); chk("R9 other cleared", v, 0);
    wr(ad(1,2), 16'h0020);
    chk("R7 alert high", alert_n, 1);

    // R5/R12 mask sweep
    for (int c = 0; c < NC; c++) for (int d = 0; d < ND; d++) begin
      wr(ad(c, 8+d), 16'hFFFF);
      mk[c][d] = 8'hFF & ~((d == ND-1) ? UM : 8'h00);
      rd(ad(c, 8+d), v);  chk("R5 mask rw", v, 16'(mk[c][d]));
      rd(ad(c, 18), v);   chk("R12 mask word", v, em(c));
    end

    // R6 masked bit, unmaskable bit
    pulse(ei(0,1,2));
    rd(ad(0,1), v); chk("R6 masked recorded", v, 16'h0004);
    chk("R6 masked no alert", alert_n, 1);
    pulse(ei(1,5,7));
    chk("R5 unmaskable alerts", alert_n, 0);
    wr(ad(1,5), 16'h0080);
    chk("R7 alert high", alert_n, 1);
    wr(ad(0,1), 16'h0004);

    // R13 inert indices
    wr(ad(0,16), 16'hFFFF); wr(ad(0,18), 16'h0000); wr(ad(0,20), 16'hFFFF);
    rd(ad(0,20), v); chk("R13 unused reads zero", v, 0);
    rd(ad(0,18), v); chk("R13 mask word kept", v, em(0));
    rd(ad(0,8), v);  chk("R13 mask kept", v, 16'h00FF);

    // clear masks
    for (int c = 0; c < NC; c++) for (int d = 0; d < ND; d++) begin
      wr(ad(c, 8+d), 16'h0000); mk[c][d] = 0;
    end
    rd(ad(1,18), v); chk("R12 mask word zero", v, 0);

    // R7 via mask write
    pulse(ei(1,2,3));
    chk("R6 alert low", alert_n, 0);
    wr(ad(1,10), 16'h0008);
    chk("R7 masked release", alert_n, 1);
    rd(ad(1,2), v); chk("R7 status kept", v, 16'h0008);
    wr(ad(1,2), 16'h0008); wr(ad(1,10), 16'h0000);

    // R8 alert response release
    pulse(ei(0,0,1));
    chk("R8 alert low", alert_n, 0);
    ara = 1'b1; tick(); ara = 1'b0;
    chk("R8 ara release", alert_n, 1);
    rd(ad(0,0), v); chk("R8 status kept", v, 16'h0002);
    pulse(ei(0,3,4));
    chk("R8 new set re-alerts", alert_n, 0);
    ara = 1'b1; evt[ei(1,0,0)] = 1'b1; tick(); ara = 1'b0; evt[ei(1,0,0)] = 1'b0;
    chk("R8 raise beats ara", alert_n, 0);

    // R9 global clear keeps masks
    wr(ad(0,10), 16'h0055);
    clr_all = 1'b1; tick(); clr_all = 1'b0;
    rd(ad(0,0), v); chk("R9 ch0 d0", v, 0);
    rd(ad(0,3), v); chk("R9 ch0 d3", v, 0);
    rd(ad(1,0), v); chk("R9 ch1 d0", v, 0);
    rd(ad(0,10), v); chk("R9 mask kept", v, 16'h0055);
    chk("R7 alert high", alert_n, 1);
    wr(ad(0,10), 16'h0000);

    // R10 run edge
    pulse(ei(0,0,0)); pulse(ei(1,1,1));
    run[0] = 1'b1; tick();
    rd(ad(0,0), v); chk("R10 ch0 cleared", v, 0);
    rd(ad(1,1), v); chk("R10 ch1 kept", v, 16'h0002);
    pulse(ei(0,0,0));
    rd(ad(0,0), v); chk("R10 level no clear", v, 16'h0001);
    run[1] = 1'b1; tick();
    rd(ad(1,1), v); chk("R10 ch1 cleared", v, 0);
    rd(ad(0,0), v); chk("R10 ch0 kept", v, 16'h0001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule